// File: doc/BRIEF.md
# Matrix Tile Configuration Loader

This block decides whether a 64-byte geometry record may become the live configuration of a bank of matrix tile registers. A load request carries the record's address and a tile-feature enable. A misaligned address or a disabled feature ends the request at once with an undefined-operation fault. Otherwise the record arrives as eight 64-bit beats under a valid/ready handshake. Once the final beat is in, the block checks the palette number, the reserved bytes, the per-tile column byte counts and the per-tile row counts. It then either reports a general-protection fault or commits the result.

A committed palette-1 record sets a per-tile valid bit for every tile whose geometry is non-empty. A committed palette-0 record wipes the configuration back to its reset state. Either successful outcome pulses a request to clear all tile data. The block itself does no memory access and holds no tile data.

Control is a four-state machine. IDLE waits for a load request. It moves to UNDEF_FAULT when the request is misaligned or the feature is disabled, and to COLLECT otherwise. COLLECT accepts beats and moves to CHECK when the eighth beat is accepted. CHECK and UNDEF_FAULT each return to IDLE after one cycle, and each registers a one-cycle done pulse with its status.

Top module: `tile_cfg_loader`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `clear_tiles_o`, `cfg_on_o`, `beat_ready_o`, `tile_valid_o`, `start_row_o`, `tile_colsb_o` and `tile_rows_o` are all zero.
- R2: Beat k (k = 0..7) carries record bytes 8k..8k+7, with byte 8k+i at bits 8i+7..8i. Gaps between beats are allowed. `done_o` is high for exactly one cycle, in the second cycle after the final beat is accepted. `status_o` is valid in that cycle and uses the codes 0 = success, 1 = undefined-operation fault, 2 = general-protection fault.
- R3: A request whose address has any of its low six bits set, or that arrives with `tile_feat_en_i` low, accepts no beats. It gives `done_o` with status 1 in the second cycle after the request, leaves the configuration unchanged and does not pulse `clear_tiles_o`.
- R4: Byte 0 is the palette number. Status is 2 if it exceeds `max_palette_i`, if its bit in `palette_mask_i` is clear (or it is 8 or more), or if it is neither 0 nor 1.
- R5: For palette 1, byte 1 is the start row (any value), and any nonzero bit in bytes 2..15 gives status 2.
- R6: For palette 1, tile t's column byte count is the little-endian 16-bit value in bytes 16+2t (low) and 17+2t (high). Status is 2 if the count exceeds 64 or if any of bytes 32..47 is nonzero. A count of exactly 64 is accepted.
- R7: For palette 1, tile t's row count is byte 48+t. Status is 2 if the count exceeds 16 or if any of bytes 56..63 is nonzero. A count of exactly 16 is accepted.
- R8: A tile whose row count and column byte count are both nonzero gets `tile_valid_o[t]` set. Both zero clears the bit. Exactly one of the two being zero gives status 2.
- R9: On status 2 the committed configuration outputs keep their previous values and `clear_tiles_o` stays low.
- R10: A record with palette 0 that passes R4 gives status 0. It zeroes every configuration output, including `cfg_on_o`, and pulses `clear_tiles_o` with `done_o`. The record's other bytes are ignored.
- R11: A palette-1 record that passes all checks gives status 0. In the cycle of `done_o` it presents the start row, the column counts, the row counts and the valid bits on the outputs, with `cfg_on_o` high and `clear_tiles_o` pulsed.
- R12: A load request raised while a load is in progress is ignored, and the running load completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, sampled in IDLE |
| rec_addr_i | input | ADDR_W | Address of the record, checked for 64-byte alignment |
| tile_feat_en_i | input | 1 | Tile feature enabled |
| max_palette_i | input | 8 | Highest palette number allowed |
| palette_mask_i | input | PAL_W | Per-palette enable bits |
| beat_valid_i | input | 1 | Record beat present |
| beat_data_i | input | BEAT_W | Record beat, lowest byte first |
| beat_ready_o | output | 1 | Beat accepted when high with valid |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 success, 1 undefined-operation fault, 2 general-protection fault |
| clear_tiles_o | output | 1 | One-cycle request to clear tile data |
| cfg_on_o | output | 1 | Configured flag |
| start_row_o | output | 8 | Committed start row |
| tile_valid_o | output | NUM_TILES | Per-tile valid bits |
| tile_colsb_o | output | 16*NUM_TILES | Committed column byte counts, tile 0 lowest |
| tile_rows_o | output | 8*NUM_TILES | Committed row counts, tile 0 lowest |

## Verification
A fault detected at request time gives its done pulse two cycles after the request edge. For a full record, done arrives two cycles after the edge that accepts the eighth beat: one cycle in CHECK, then the registered result. The bench drives on falling edges and samples on falling edges. For every load it confirms that done is low in the CHECK cycle, high on the following one and low again after that. The status, the clear pulse and all committed fields are read in the done cycle or the cycle after it, when they have already settled. Loads that fault are followed by a comparison against the configuration from the last successful load.

// File: rtl/tile_cfg_pkg.sv
package tile_cfg_pkg;

    typedef enum logic [1:0] {
        ST_OK  = 2'd0,
        ST_UDF = 2'd1,
        ST_GPF = 2'd2
    } ld_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COLLECT,
        S_CHECK,
        S_UNDEF_FAULT
    } ld_state_e;

endpackage

// File: rtl/tile_cfg_beats.sv
module tile_cfg_beats #(
    parameter int BEAT_W = 64,
    parameter int NBEATS = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     restart_i,
    input  logic                     take_i,
    input  logic [BEAT_W-1:0]        beat_data_i,
    output logic [NBEATS*BEAT_W-1:0] rec_o,
    output logic                     last_o
);
    localparam int CNT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (take_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    assign last_o = take_i && (cnt_q == CNT_W'(NBEATS - 1));

    for (genvar k = 0; k < NBEATS; k++) begin : g_beat
        logic [BEAT_W-1:0] beat_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                beat_q <= '0;
            end else if (take_i && (cnt_q == CNT_W'(k))) begin
                beat_q <= beat_data_i;
            end
        end
        assign rec_o[k*BEAT_W +: BEAT_W] = beat_q;
    end

    AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |=> $stable(rec_o)); // R2

endmodule

// File: rtl/tile_cfg_check.sv
module tile_cfg_check #(
    parameter int NUM_TILES = 8,
    parameter int MAX_COLSB = 64,
    parameter int MAX_ROWS  = 16,
    parameter int PAL_W     = 8
) (
    input  logic [511:0]           rec_i,
    input  logic [7:0]             max_pal_i,
    input  logic [PAL_W-1:0]       pal_mask_i,
    output logic                   err_o,
    output logic                   pal_zero_o,
    output logic [7:0]             start_row_o,
    output logic [16*NUM_TILES-1:0] colsb_o,
    output logic [8*NUM_TILES-1:0] rows_o,
    output logic [NUM_TILES-1:0]   valid_o
);
    localparam int REC_BYTES = 64;
    localparam int COL_BASE  = 16;
    localparam int ROW_BASE  = 48;
    localparam int COL_END   = COL_BASE + 2 * NUM_TILES;
    localparam int ROW_END   = ROW_BASE + NUM_TILES;
    localparam logic [15:0] COL_LIM = 16'(MAX_COLSB);
    localparam logic [7:0]  ROW_LIM = 8'(MAX_ROWS);

    logic [7:0]  pal;
    logic        pal_bad;
    logic        rsv_bad;
    logic        geom_bad;
    logic        mask_hit;
    logic [15:0] cb;
    logic [7:0]  rw;
    logic [7:0]  by;

    always_comb begin
        pal      = rec_i[7:0];
        mask_hit = 1'b0;
        for (int i = 0; i < PAL_W; i++) begin
            if (pal == 8'(i)) mask_hit = pal_mask_i[i];
        end
        pal_bad = (pal > max_pal_i) || !mask_hit || (pal > 8'd1);

        rsv_bad = 1'b0;
        for (int b = 2; b < REC_BYTES; b++) begin
            by = rec_i[8*b +: 8];
            if (by != 8'd0) begin
                if (b < COL_BASE) rsv_bad = 1'b1;
                if (b >= COL_END && b < ROW_BASE) rsv_bad = 1'b1;
                if (b >= ROW_END) rsv_bad = 1'b1;
            end
        end

        geom_bad = 1'b0;
        cb       = '0;
        rw       = '0;
        for (int t = 0; t < NUM_TILES; t++) begin
            cb = rec_i[8*(COL_BASE + 2*t) +: 16];
            rw = rec_i[8*(ROW_BASE + t) +: 8];
            colsb_o[16*t +: 16] = cb;
            rows_o[8*t +: 8]    = rw;
            valid_o[t]          = (cb != 16'd0) && (rw != 8'd0);
            if (cb > COL_LIM) geom_bad = 1'b1;
            if (rw > ROW_LIM) geom_bad = 1'b1;
            if ((cb == 16'd0) != (rw == 8'd0)) geom_bad = 1'b1;
        end

        pal_zero_o  = (pal == 8'd0);
        start_row_o = rec_i[15:8];
        err_o       = pal_bad || (!pal_zero_o && (rsv_bad || geom_bad));
    end

endmodule

// File: rtl/tile_cfg_loader.sv
module tile_cfg_loader #(
    parameter int ADDR_W    = 48,
    parameter int BEAT_W    = 64,
    parameter int NUM_TILES = 8,
    parameter int MAX_COLSB = 64,
    parameter int MAX_ROWS  = 16,
    parameter int PAL_W     = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         rec_addr_i,
    input  logic                      tile_feat_en_i,
    input  logic [7:0]                max_palette_i,
    input  logic [PAL_W-1:0]          palette_mask_i,
    input  logic                      beat_valid_i,
    input  logic [BEAT_W-1:0]         beat_data_i,
    output logic                      beat_ready_o,
    output logic                      done_o,
    output logic [1:0]                status_o,
    output logic                      clear_tiles_o,
    output logic                      cfg_on_o,
    output logic [7:0]                start_row_o,
    output logic [NUM_TILES-1:0]      tile_valid_o,
    output logic [16*NUM_TILES-1:0]   tile_colsb_o,
    output logic [8*NUM_TILES-1:0]    tile_rows_o
);
    import tile_cfg_pkg::*;

    localparam int REC_BYTES = 64;
    localparam int REC_BITS  = 8 * REC_BYTES;
    localparam int NBEATS    = REC_BITS / BEAT_W;

    ld_state_e  state_q, state_d;
    ld_status_e status_q;

    logic [REC_BITS-1:0]      rec;
    logic                     take, last, restart, misaligned;
    logic [ADDR_W-1:0]        addr_off;
    logic                     chk_err, chk_pal0;
    logic [7:0]               chk_row;
    logic [16*NUM_TILES-1:0]  chk_cols;
    logic [8*NUM_TILES-1:0]   chk_rows;
    logic [NUM_TILES-1:0]     chk_valid;

    assign addr_off   = rec_addr_i & ADDR_W'(REC_BYTES - 1);
    assign misaligned = |addr_off;
    assign beat_ready_o = (state_q == S_COLLECT);
    assign take       = beat_valid_i && beat_ready_o;
    assign restart    = (state_q == S_IDLE) && start_i;

    tile_cfg_beats #(.BEAT_W(BEAT_W), .NBEATS(NBEATS)) u_beats (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .restart_i   (restart),
        .take_i      (take),
        .beat_data_i (beat_data_i),
        .rec_o       (rec),
        .last_o      (last)
    );

    tile_cfg_check #(
        .NUM_TILES (NUM_TILES),
        .MAX_COLSB (MAX_COLSB),
        .MAX_ROWS  (MAX_ROWS),
        .PAL_W     (PAL_W)
    ) u_check (
        .rec_i       (rec),
        .max_pal_i   (max_palette_i),
        .pal_mask_i  (palette_mask_i),
        .err_o       (chk_err),
        .pal_zero_o  (chk_pal0),
        .start_row_o (chk_row),
        .colsb_o     (chk_cols),
        .rows_o      (chk_rows),
        .valid_o     (chk_valid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = (misaligned || !tile_feat_en_i) ? S_UNDEF_FAULT : S_COLLECT;
                end
            end
            S_COLLECT:     if (last) state_d = S_CHECK;
            S_CHECK:       state_d = S_IDLE;
            S_UNDEF_FAULT: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // registered outputs and committed configuration
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_o        <= 1'b0;
            status_q      <= ST_OK;
            clear_tiles_o <= 1'b0;
            cfg_on_o      <= 1'b0;
            start_row_o   <= '0;
            tile_valid_o  <= '0;
            tile_colsb_o  <= '0;
            tile_rows_o   <= '0;
        end else begin
            done_o        <= 1'b0;
            clear_tiles_o <= 1'b0;
            unique case (state_q)
                S_CHECK: begin
                    done_o <= 1'b1;
                    if (chk_err) begin
                        status_q <= ST_GPF;
                    end else begin
                        status_q      <= ST_OK;
                        clear_tiles_o <= 1'b1;
                        if (chk_pal0) begin
                            cfg_on_o     <= 1'b0;
                            start_row_o  <= '0;
                            tile_valid_o <= '0;
                            tile_colsb_o <= '0;
                            tile_rows_o  <= '0;
                        end else begin
                            cfg_on_o     <= 1'b1;
                            start_row_o  <= chk_row;
                            tile_valid_o <= chk_valid;
                            tile_colsb_o <= chk_cols;
                            tile_rows_o  <= chk_rows;
                        end
                    end
                end
                S_UNDEF_FAULT: begin
                    done_o   <= 1'b1;
                    status_q <= ST_UDF;
                end
                S_IDLE, S_COLLECT: ;
            endcase
        end
    end

    assign status_o = status_q;

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R2
    AST_CLEAR_ON_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_tiles_o |-> (done_o && status_o == 2'd0)); // R9
    AST_FAULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o != 2'd0) |-> ($stable(cfg_on_o) && $stable(tile_valid_o)
            && $stable(tile_colsb_o) && $stable(tile_rows_o) && $stable(start_row_o))); // R9
    AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_COLLECT) |=> (state_q == S_COLLECT || state_q == S_CHECK)); // R12
    AST_UD_NO_BEATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o == 2'd1) |-> $past(!beat_ready_o)); // R3

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_geom_chk
        AST_VALID_GEOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tile_valid_o[t] |-> (tile_rows_o[8*t +: 8] != 8'd0
                && tile_colsb_o[16*t +: 16] != 16'd0)); // R8
    end

endmodule

// File: tb/tile_cfg_loader_tb.sv
module tile_cfg_loader_tb_top;
    localparam int ADDR_W = 48;
    localparam int NT     = 8;

    typedef struct packed {
        int         idx;
        logic [7:0] val;
        logic [7:0] mp;
        logic [7:0] mask;
        logic [1:0] st;
        int         req;
    } vec_t;

    // byte index, byte value, max palette, palette mask, expected status, requirement
    localparam vec_t VECS [16] = '{
        '{0,  8'h01, 8'd1, 8'h03, 2'd0, 11}, // R11 base record
        '{0,  8'h02, 8'd3, 8'hFF, 2'd2, 4},  // R4 unsupported palette
        '{0,  8'h01, 8'd0, 8'hFF, 2'd2, 4},  // R4 above max palette
        '{0,  8'h01, 8'd1, 8'h01, 2'd2, 4},  // R4 palette masked off
        '{2,  8'h01, 8'd1, 8'h03, 2'd2, 5},  // R5 reserved byte 2
        '{15, 8'h80, 8'd1, 8'h03, 2'd2, 5},  // R5 reserved byte 15
        '{16, 8'd64, 8'd1, 8'h03, 2'd0, 6},  // R6 colsb at limit
        '{16, 8'd65, 8'd1, 8'h03, 2'd2, 6},  // R6 colsb over limit
        '{17, 8'h01, 8'd1, 8'h03, 2'd2, 6},  // R6 colsb high byte
        '{40, 8'h01, 8'd1, 8'h03, 2'd2, 6},  // R6 unused column byte
        '{48, 8'd16, 8'd1, 8'h03, 2'd0, 7},  // R7 rows at limit
        '{48, 8'd17, 8'd1, 8'h03, 2'd2, 7},  // R7 rows over limit
        '{60, 8'h01, 8'd1, 8'h03, 2'd2, 7},  // R7 unused row byte
        '{26, 8'h04, 8'd1, 8'h03, 2'd2, 8},  // R8 cols without rows
        '{53, 8'h02, 8'd1, 8'h03, 2'd2, 8},  // R8 rows without cols
        '{1,  8'hFF, 8'd1, 8'h03, 2'd0, 11}  // R11 any start row
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic feat_i = 1'b1;
    logic [7:0] maxpal_i = 8'd1;
    logic [7:0] mask_i = 8'h03;
    logic bvalid = 1'b0;
    logic [63:0] bdata = '0;
    logic bready, done, clr, cfg_on;
    logic [1:0] status;
    logic [7:0] srow;
    logic [NT-1:0] tvalid;
    logic [16*NT-1:0] tcols;
    logic [8*NT-1:0] trows;

    int checks = 0;
    int fails = 0;

    logic          e_on = 1'b0;
    logic [7:0]    e_row = '0;
    logic [NT-1:0] e_valid = '0;
    logic [127:0]  e_cols = '0;
    logic [63:0]   e_rows = '0;

    always #2 clk = ~clk;

    tile_cfg_loader dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rec_addr_i(addr_i),
        .tile_feat_en_i(feat_i), .max_palette_i(maxpal_i), .palette_mask_i(mask_i),
        .beat_valid_i(bvalid), .beat_data_i(bdata), .beat_ready_o(bready),
        .done_o(done), .status_o(status), .clear_tiles_o(clr), .cfg_on_o(cfg_on),
        .start_row_o(srow), .tile_valid_o(tvalid), .tile_colsb_o(tcols), .tile_rows_o(trows)
    );

    task automatic check_val(input string req, input string what,
                             input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] base_rec();
        logic [511:0] r = '0;
        r[7:0]  = 8'd1;
        r[15:8] = 8'd3;
        for (int t = 0; t < NT; t++) begin
            if (t != 5) begin
                r[8*(16+2*t) +: 16] = 16'(4*(t+1));
                r[8*(48+t) +: 8]    = 8'(t+1);
            end
        end
        return r;
    endfunction

    function automatic void model_commit(input logic [511:0] r);
        if (r[7:0] == 8'd0) begin
            e_on = 1'b0; e_row = '0; e_valid = '0; e_cols = '0; e_rows = '0;
        end else begin
            e_on   = 1'b1;
            e_row  = r[15:8];
            e_cols = r[8*16 +: 128];
            e_rows = r[8*48 +: 64];
            for (int t = 0; t < NT; t++) e_valid[t] = (e_rows[8*t +: 8] != 8'd0);
        end
    endfunction

    task automatic check_cfg(input string req);
        check_val(req, "cfg_on", 128'(cfg_on), 128'(e_on));
        check_val(req, "start_row", 128'(srow), 128'(e_row));
        check_val(req, "tile_valid", 128'(tvalid), 128'(e_valid));
        check_val(req, "colsb", tcols, e_cols);
        check_val(req, "rows", 128'(trows), 128'(e_rows));
    endtask

    task automatic do_load(input logic [511:0] rec, input logic [ADDR_W-1:0] addr,
                           input logic feat, input logic [7:0] mp, input logic [7:0] mk,
                           input logic noisy,
                           output logic [1:0] st, output logic cl, output logic tok);
        tok = 1'b1;
        @(negedge clk);
        start_i = 1'b1; addr_i = addr; feat_i = feat; maxpal_i = mp; mask_i = mk;
        @(negedge clk);
        start_i = 1'b0;
        if (addr[5:0] != 6'd0 || !feat) begin
            if (done || bready) tok = 1'b0;
            @(negedge clk);
            if (!done) tok = 1'b0;
        end else begin
            for (int k = 0; k < 8; k++) begin
                if (noisy && k == 3) begin
                    bvalid = 1'b0; start_i = 1'b1; addr_i = 48'h1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
                bvalid = 1'b1;
                bdata  = rec[64*k +: 64];
                if (!bready) tok = 1'b0;
                @(negedge clk);
            end
            bvalid = 1'b0;
            if (done) tok = 1'b0;
            @(negedge clk);
            if (!done) tok = 1'b0;
        end
        st = status;
        cl = clr;
        @(negedge clk);
        if (done) tok = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [511:0] r;
        logic [1:0]   st;
        logic         cl, tok;

        // R1 reset state
        repeat (3) @(negedge clk);
        check_val("R1", "done in reset", 128'(done), 0);
        check_val("R1", "ready in reset", 128'(bready), 0);
        check_cfg("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1", "done after reset", 128'(done), 0);
        check_val("R1", "clear after reset", 128'(clr), 0);
        check_cfg("R1");

        // table walk
        foreach (VECS[i]) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            r = base_rec();
            r[8*VECS[i].idx +: 8] = VECS[i].val;
            do_load(r, 48'h1000, 1'b1, VECS[i].mp, VECS[i].mask, 1'b0, st, cl, tok);
            check_val("R2", "done timing", 128'(tok), 1);
            check_val(rq, "status", 128'(st), 128'(VECS[i].st));
            check_val(VECS[i].st == 2'd0 ? rq : "R9", "clear pulse", 128'(cl),
                      128'(VECS[i].st == 2'd0));
            if (VECS[i].st == 2'd0) model_commit(r);
            check_cfg(VECS[i].st == 2'd0 ? rq : "R9");
        end

        // R3 misaligned address
        do_load(base_rec(), 48'h1020, 1'b1, 8'd1, 8'h03, 1'b0, st, cl, tok);
        check_val("R3", "misaligned timing", 128'(tok), 1);
        check_val("R3", "misaligned status", 128'(st), 1);
        check_val("R3", "misaligned clear", 128'(cl), 0);
        check_cfg("R3");

        // R3 feature disabled
        r = '0;
        do_load(r, 48'h2000, 1'b0, 8'd1, 8'h03, 1'b0, st, cl, tok);
        check_val("R3", "disabled timing", 128'(tok), 1);
        check_val("R3", "disabled status", 128'(st), 1);
        check_val("R3", "disabled clear", 128'(cl), 0);
        check_cfg("R3");

        // R10 palette zero with junk bytes
        r = '0;
        r[8*5 +: 8]  = 8'hAA;
        r[8*16 +: 8] = 8'hFF;
        r[8*60 +: 8] = 8'h01;
        do_load(r, 48'h3000, 1'b1, 8'd1, 8'h03, 1'b0, st, cl, tok);
        check_val("R10", "palette0 status", 128'(st), 0);
        check_val("R10", "palette0 clear", 128'(cl), 1);
        model_commit(r);
        check_cfg("R10");

        // R4 palette zero masked off
        r = '0;
        do_load(r, 48'h3040, 1'b1, 8'd1, 8'h02, 1'b0, st, cl, tok);
        check_val("R4", "palette0 masked status", 128'(st), 2);
        check_cfg("R4");

        // R12 start raised mid-load, with a beat gap
        r = base_rec();
        do_load(r, 48'h4000, 1'b1, 8'd1, 8'h03, 1'b1, st, cl, tok);
        check_val("R12", "busy start timing", 128'(tok), 1);
        check_val("R12", "busy start status", 128'(st), 0);
        model_commit(r);
        check_cfg("R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule